// File: doc/BRIEF.md
# Maskable Level Interrupt Controller

This block merges a bank of level-sensitive interrupt request lines into one interrupt signal for a processor. Each source has a disable bit in a mask register. A 1 in that bit blocks the source. Software never writes the mask directly. It uses two alias registers instead: writing ones to one alias disables the selected sources, and writing ones to the other alias enables them. Each alias write changes only the bits that were written as 1, so no read-modify-write sequence is needed.

The request lines are asynchronous to the block's clock. They pass through a two-flop synchronizer and then into a status register. A source that is active in status and not blocked by the mask counts as pending. The registered CPU interrupt output is high while any source is pending. The status, mask and pending words can all be read. A combinational side output gives the highest-numbered pending source and a valid flag, so that a dispatcher can pick a handler without scanning bits.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFFFFFFFF (all sources disabled), status and pending read 0, cpu_irq is low and top_vld is low.
- R2: A change on a request line shows up in status (and top_vld) on the third rising clock edge after it is driven, after a two-flop synchronizer and the status register.
- R3: A write to byte offset 0x08 sets every mask bit whose write data bit is 1 and leaves the mask bits written as 0 unchanged.
- R4: A write to byte offset 0x0C clears every mask bit whose write data bit is 1 and leaves the mask bits written as 0 unchanged.
- R5: The pending word (offset 0x10) equals status AND NOT mask. A masked source never shows in pending.
- R6: cpu_irq is the OR of all pending bits, registered one clock later. Because sources are level-sensitive, it drops once the causing line falls or its source becomes masked.
- R7: Reads are registered: bus_rdata, one clock after bus_addr is presented, shows status at 0x00, mask at 0x04 and pending at 0x10. Offsets 0x08, 0x0C and all other offsets read as 0.
- R8: Writes to offsets 0x00, 0x04, 0x10 and to unmapped offsets leave the mask unchanged.
- R9: top_idx gives the highest-numbered pending bit and top_vld is high exactly when pending is nonzero. When top_vld is low, top_idx is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset into the register window |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the offset presented in the previous cycle |
| irq_lines | input | 32 | Level-sensitive request inputs, one per source |
| cpu_irq | output | 1 | Combined interrupt to the processor |
| top_idx | output | 5 | Index of the highest-numbered pending source |
| top_vld | output | 1 | High when any source is pending |

## Verification
The main function is driven with request and mask combinations that each separate a different mistake:
- A single low source and the two extreme sources together show whether the index encoder picks the highest bit rather than the lowest.
- All lines active under a partial mask shows whether pending is gated by the mask and whether the mask polarity is inverted.
- Overlapping clear and set writes show whether zero bits in an alias write really leave the mask alone.
- A checkerboard request pattern against an interleaved mask exposes swapped or shifted bit lanes.

Directed tests then count the synchronizer and output latency edge by edge. They also confirm that writes to the read-only and unmapped offsets change nothing.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  // Byte offsets of the register window
  localparam int OFS_STATUS  = 'h00;
  localparam int OFS_MASK    = 'h04;
  localparam int OFS_DISABLE = 'h08;
  localparam int OFS_ENABLE  = 'h0C;
  localparam int OFS_PENDING = 'h10;

  typedef enum logic [2:0] {
    SEL_STATUS,
    SEL_MASK,
    SEL_PENDING,
    SEL_ZERO
  } rd_sel_e;
endpackage

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lvl_irq_mask.sv
module lvl_irq_mask #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst)         mask <= '1;
    else if (set_we) mask <= mask | wdata;
    else if (clr_we) mask <= mask & ~wdata;
  end
endmodule

// File: rtl/lvl_irq_prio.sv
module lvl_irq_prio #(
  parameter int WIDTH = 32,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] req,
  output logic [IDX_W-1:0] idx,
  output logic             vld
);
  always_comb begin
    idx = '0;
    vld = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (req[i]) begin
        idx = IDX_W'(i);
        vld = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] irq_lines,
  output logic               cpu_irq,
  output logic [IDX_W-1:0]   top_idx,
  output logic               top_vld
);
  logic [NUM_SRC-1:0] sync_q;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] pending;
  logic               hit_set;
  logic               hit_clr;
  rd_sel_e            rd_sel;

  lvl_irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(irq_lines), .q(sync_q)
  );

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= sync_q;
  end

  assign hit_set = bus_we && (bus_addr == ADDR_W'(OFS_DISABLE));
  assign hit_clr = bus_we && (bus_addr == ADDR_W'(OFS_ENABLE));

  lvl_irq_mask #(.WIDTH(NUM_SRC)) u_mask (
    .clk(clk), .rst(rst), .set_we(hit_set), .clr_we(hit_clr),
    .wdata(bus_wdata), .mask(mask_q)
  );

  assign pending = status_q & ~mask_q;

  lvl_irq_prio #(.WIDTH(NUM_SRC)) u_prio (
    .req(pending), .idx(top_idx), .vld(top_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) cpu_irq <= 1'b0;
    else     cpu_irq <= |pending;
  end

  always_comb begin
    if (bus_addr == ADDR_W'(OFS_STATUS))       rd_sel = SEL_STATUS;
    else if (bus_addr == ADDR_W'(OFS_MASK))    rd_sel = SEL_MASK;
    else if (bus_addr == ADDR_W'(OFS_PENDING)) rd_sel = SEL_PENDING;
    else                                       rd_sel = SEL_ZERO;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (rd_sel)
        SEL_STATUS:  bus_rdata <= status_q;
        SEL_MASK:    bus_rdata <= mask_q;
        SEL_PENDING: bus_rdata <= pending;
        default:     bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk
  import lvl_irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 5,
  parameter int IDX_W   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_we,
  input logic [NUM_SRC-1:0] bus_wdata,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] pending,
  input logic               cpu_irq,
  input logic [IDX_W-1:0]   top_idx,
  input logic               top_vld
);
  // R3: disable alias forces written ones into the mask
  a_r3_set_alias: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(OFS_DISABLE)) |=>
      ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

  // R4: enable alias removes written ones from the mask
  a_r4_clr_alias: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(OFS_ENABLE)) |=>
      ((mask_q & $past(bus_wdata)) == '0));

  // R8: no alias write, no mask change
  a_r8_mask_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && (bus_addr == ADDR_W'(OFS_DISABLE) || bus_addr == ADDR_W'(OFS_ENABLE)))
      |=> $stable(mask_q));

  // R5: a masked source never appears in pending
  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (pending & mask_q) == '0);

  // R6: output follows any-pending with one register
  a_r6_irq_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cpu_irq == ($past(pending) != '0)));

  // R9: index names the top pending bit
  a_r9_idx_top: assert property (@(posedge clk) disable iff (rst)
    top_vld |-> ((pending >> top_idx) == NUM_SRC'(1)));

  a_r9_vld_zero: assert property (@(posedge clk) disable iff (rst)
    (pending == '0) |-> (!top_vld && top_idx == '0));
endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .mask_q(mask_q), .pending(pending),
  .cpu_irq(cpu_irq), .top_idx(top_idx), .top_vld(top_vld)
);

// File: tb/tb_lvl_irq_ctrl.sv
module tb_lvl_irq_ctrl;
  localparam int N = 32;
  localparam int AW = 5;
  localparam int NV = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic [N-1:0]  irq_lines = '0;
  logic          cpu_irq;
  logic [4:0]    top_idx;
  logic          top_vld;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lvl_irq_ctrl dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines),
    .cpu_irq(cpu_irq), .top_idx(top_idx), .top_vld(top_vld)
  );

  // request, enable-alias data, disable-alias data, expected pending, expected index
  localparam logic [N-1:0] V_REQ [NV] = '{32'h0000_0000, 32'h0000_0001, 32'h8000_0001,
    32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hA5A5_A5A5, 32'h0001_0000};
  localparam logic [N-1:0] V_CLR [NV] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
    32'h0000_FF00, 32'h0000_FF00, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h0003_0000};
  localparam logic [N-1:0] V_SET [NV] = '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
    32'h0000_0000, 32'h0000_0F00, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0002_0000};
  localparam logic [N-1:0] V_PEND [NV] = '{32'h0000_0000, 32'h0000_0001, 32'h8000_0001,
    32'h0000_FF00, 32'h0000_F000, 32'h0000_0000, 32'h0505_0505, 32'h0001_0000};
  localparam int V_IDX [NV] = '{0, 0, 31, 15, 15, 0, 26, 16};

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin : watchdog
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [N-1:0] r;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);

    // R1: reset state
    rd(5'h04, r); chk("R1 mask", r, 32'hFFFF_FFFF);
    rd(5'h00, r); chk("R1 status", r, '0);
    rd(5'h10, r); chk("R1 pending", r, '0);
    chk("R1 cpu_irq", N'(cpu_irq), '0);
    chk("R1 top_vld", N'(top_vld), '0);

    // Vector table: main function
    for (int i = 0; i < NV; i++) begin
      wr(5'h08, 32'hFFFF_FFFF);
      wr(5'h0C, V_CLR[i]);
      wr(5'h08, V_SET[i]);
      irq_lines = V_REQ[i];
      wait_cyc(6);
      rd(5'h04, r); chk("R3/R4 mask", r, ~V_CLR[i] | V_SET[i]);
      rd(5'h00, r); chk("R2 status", r, V_REQ[i]);
      rd(5'h10, r); chk("R5 pending", r, V_PEND[i]);
      chk("R6 cpu_irq", N'(cpu_irq), N'(V_PEND[i] != '0));
      chk("R9 top_vld", N'(top_vld), N'(V_PEND[i] != '0));
      chk("R9 top_idx", N'(top_idx), N'(V_IDX[i]));
    end

    // R3/R4: zero bits in alias writes leave the mask unchanged (mask now fffeffff)
    wr(5'h08, '0); rd(5'h04, r); chk("R3 zero-set", r, 32'hFFFE_FFFF);
    wr(5'h0C, '0); rd(5'h04, r); chk("R4 zero-clr", r, 32'hFFFE_FFFF);

    // R8: writes elsewhere ignored
    wr(5'h04, '0);
    wr(5'h00, '0);
    wr(5'h10, '0);
    wr(5'h18, '0);
    rd(5'h04, r); chk("R8 mask kept", r, 32'hFFFE_FFFF);

    // R7: alias and unmapped reads give zero
    rd(5'h08, r); chk("R7 set alias read", r, '0);
    rd(5'h0C, r); chk("R7 clr alias read", r, '0);
    rd(5'h14, r); chk("R7 unmapped read", r, '0);

    // R2/R6: latency, edge by edge, on source 5
    irq_lines = '0;
    wr(5'h08, 32'hFFFF_FFFF);
    wr(5'h0C, 32'h0000_0020);
    wait_cyc(5);
    irq_lines = 32'h0000_0020;
    wait_cyc(2);
    chk("R2 not yet after 2 edges", N'(top_vld), '0);
    wait_cyc(1);
    chk("R2 visible after 3 edges", N'(top_vld), 1);
    chk("R2 idx", N'(top_idx), 5);
    chk("R6 irq not yet", N'(cpu_irq), '0);
    wait_cyc(1);
    chk("R6 irq raised", N'(cpu_irq), 1);
    // level: line drop clears the output
    irq_lines = '0;
    wait_cyc(3);
    chk("R6 vld drop", N'(top_vld), '0);
    chk("R6 irq still high", N'(cpu_irq), 1);
    wait_cyc(1);
    chk("R6 irq dropped", N'(cpu_irq), '0);

    // R6: masking an active source drops the output
    irq_lines = 32'h0000_0020;
    wait_cyc(5);
    chk("R6 irq active", N'(cpu_irq), 1);
    wr(5'h08, 32'h0000_0020);
    wait_cyc(1);
    chk("R6 irq masked", N'(cpu_irq), '0);
    rd(5'h00, r); chk("R5 status keeps masked line", r, 32'h0000_0020);
    rd(5'h10, r); chk("R5 pending masked", r, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule